// File: doc/BRIEF.md
# Vector Byte Shuffle Unit

This block rearranges the bytes of a 128-bit vector. The vector is split into sixteen 8-bit lanes. One operand serves as a lookup table of sixteen bytes. For each output lane, an index picks which table byte lands in that lane. The result is available combinationally in the same cycle that the operands are presented. A strobe-gated output register keeps a copy of it.

There are three active selection modes. In the first, the indices come from a second vector, with one byte per lane. In the second, the indices come from a packed 64-bit control word that holds sixteen 4-bit fields. In the third, two data vectors are joined into a table of 32 bytes, and each lane is indexed by a 5-bit value from the index vector. A fourth mode code blanks the result. A typical use is to place the unit in an execute stage: the issue logic supplies the operands and the mode, and it raises the valid strobe when the result is to be kept.

Byte j of any 128-bit port occupies bits [8j+7:8j]. Nibble j of the control word occupies bits [4j+3:4j].

Top module: `byte_shuffle_unit`

## Requirements
- R1: With mode = 0, output byte j equals byte k of `tableA`, where k is bits [3:0] of index byte j of `idxVec`. This holds whenever bit 7 of that index byte is clear. Bits [6:4] of the index byte have no effect.
- R2: With mode = 0, output byte j is 0x00 whenever bit 7 of index byte j of `idxVec` is set.
- R3: With mode = 1, output byte j equals byte n of `tableA`, where n is nibble j of `ctrlWord`. Lane 0 uses the least significant nibble. `idxVec` has no effect on the output in this mode.
- R4: With mode = 2, the low 5 bits s of index byte j select entry s of a 32-byte table. Entries 0 to 15 are the bytes of `tableA`, and entries 16 to 31 are the bytes of `tableB`. Bits [7:5] of the index byte have no effect, so no lane is zeroed in this mode.
- R5: With mode = 3, `comboOut` is all zeros.
- R6: `comboOut` reflects the current inputs within the same cycle, with no register in its path.
- R7: At a rising clock edge where `inValid` is 1, `regOut` loads the value of `comboOut`. `regValid` is 1 during the cycle after any edge at which `inValid` was 1, and 0 during the cycle after any edge at which it was 0.
- R8: At a rising clock edge where `inValid` is 0, `regOut` keeps its previous value.
- R9: While `rstN` is low, `regOut` is cleared to zero and `regValid` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe that loads the output register |
| mode | input | 2 | 0 index vector, 1 control word, 2 two-table, 3 blank |
| tableA | input | 128 | Primary byte table |
| tableB | input | 128 | Upper half of the table in two-table mode |
| idxVec | input | 128 | Per-lane index bytes |
| ctrlWord | input | 64 | Sixteen packed 4-bit lane indices |
| comboOut | output | 128 | Combinational shuffle result |
| regOut | output | 128 | Registered shuffle result |
| regValid | output | 1 | The registered result was loaded on the last edge |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the lane zeroing caused by bit 7 of an index in mode 0;
- the blank mode;
- the register loading the combinational result on a strobe and holding it otherwise;
- the one-cycle valid flag.

The lane routing itself can only be shown by the bench's scenarios, which compare each result against a model: identity, reversal and mixed index patterns, the packed nibble order of the control word, the boundary between the two tables at index 15/16, and the upper index bits being ignored. The same applies to the reset contents and to the index vector having no effect in control-word mode.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  localparam int LANE_W   = 8;
  localparam int LANE_CNT = 16;
  localparam int NIB_W    = $clog2(LANE_CNT);
  localparam int SEL_W    = NIB_W + 1;
  localparam int VEC_W    = LANE_W * LANE_CNT;
  localparam int CTRL_W   = NIB_W * LANE_CNT;

  typedef enum logic [1:0] {
    MODE_VEC  = 2'd0,
    MODE_IMM  = 2'd1,
    MODE_DUAL = 2'd2,
    MODE_OFF  = 2'd3
  } shufMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeImm;    // lane index from packed control word
    logic takeDual;   // 5-bit select over joined tables
    logic honorZero;  // index MSB forces lane to zero
    logic blankAll;   // whole result forced to zero
    logic capture;    // load output register
  } shufCtl_t;
endpackage

// File: rtl/shuf_ctrl.sv
module shuf_ctrl
  import shuf_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       inValid,
  output shufCtl_t   ctl
);
  shufMode_e modeSel;
  assign modeSel = shufMode_e'(mode);

  always_comb begin
    ctl = '0;
    ctl.capture = inValid;
    unique case (modeSel)
      MODE_VEC:  ctl.honorZero = 1'b1;
      MODE_IMM:  ctl.takeImm   = 1'b1;
      MODE_DUAL: ctl.takeDual  = 1'b1;
      MODE_OFF:  ctl.blankAll  = 1'b1;
      default:   ctl.blankAll  = 1'b1;
    endcase
  end
endmodule

// File: rtl/shuf_datapath.sv
module shuf_datapath
  import shuf_pkg::*;
(
  input  shufCtl_t            ctl,
  input  logic [VEC_W-1:0]    tableA,
  input  logic [VEC_W-1:0]    tableB,
  input  logic [VEC_W-1:0]    idxVec,
  input  logic [CTRL_W-1:0]   ctrlWord,
  output logic [VEC_W-1:0]    laneOut
);
  localparam int TAB_W = 2 * VEC_W;

  logic [TAB_W-1:0]  joinedTab;
  logic [LANE_W-1:0] laneVal [LANE_CNT];

  assign joinedTab = {tableB, tableA};

  for (genvar g = 0; g < LANE_CNT; g++) begin : gLane
    logic [LANE_W-1:0] idxByte;
    logic [NIB_W-1:0]  immNib;
    logic [SEL_W-1:0]  sel;
    logic              zeroLane;

    assign idxByte = idxVec[g*LANE_W +: LANE_W];
    assign immNib  = ctrlWord[g*NIB_W +: NIB_W];

    always_comb begin
      if (ctl.takeImm)
        sel = {1'b0, immNib};
      else if (ctl.takeDual)
        sel = idxByte[SEL_W-1:0];
      else
        sel = {1'b0, idxByte[NIB_W-1:0]};
      zeroLane = ctl.blankAll | (ctl.honorZero & idxByte[LANE_W-1]);
    end

    assign laneVal[g] = zeroLane ? '0 : joinedTab[int'(sel)*LANE_W +: LANE_W];
    assign laneOut[g*LANE_W +: LANE_W] = laneVal[g];
  end
endmodule

// File: rtl/shuf_outreg.sv
module shuf_outreg
  import shuf_pkg::*;
#(
  parameter bit REG_STAGE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capture,
  input  logic [VEC_W-1:0] dIn,
  output logic [VEC_W-1:0] qOut,
  output logic             qValid
);
  if (REG_STAGE) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        qOut   <= '0;
        qValid <= 1'b0;
      end else begin
        qValid <= capture;
        if (capture) qOut <= dIn;
      end
    end
  end else begin : gPass
    assign qOut   = dIn;
    assign qValid = capture;
  end
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
  import shuf_pkg::*;
#(
  parameter bit REG_STAGE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        mode,
  input  logic [VEC_W-1:0]  tableA,
  input  logic [VEC_W-1:0]  tableB,
  input  logic [VEC_W-1:0]  idxVec,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic [VEC_W-1:0]  comboOut,
  output logic [VEC_W-1:0]  regOut,
  output logic              regValid
);
  shufCtl_t ctl;

  shuf_ctrl uCtrl (
    .mode    (mode),
    .inValid (inValid),
    .ctl     (ctl)
  );

  shuf_datapath uPath (
    .ctl      (ctl),
    .tableA   (tableA),
    .tableB   (tableB),
    .idxVec   (idxVec),
    .ctrlWord (ctrlWord),
    .laneOut  (comboOut)
  );

  shuf_outreg #(.REG_STAGE(REG_STAGE)) uOut (
    .clk     (clk),
    .rstN    (rstN),
    .capture (ctl.capture),
    .dIn     (comboOut),
    .qOut    (regOut),
    .qValid  (regValid)
  );
endmodule

// File: rtl/shuf_chk.sv
module shuf_chk
  import shuf_pkg::*;
#(
  parameter bit REG_STAGE = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        mode,
  input logic [VEC_W-1:0]  tableA,
  input logic [VEC_W-1:0]  tableB,
  input logic [VEC_W-1:0]  idxVec,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic [VEC_W-1:0]  comboOut,
  input logic [VEC_W-1:0]  regOut,
  input logic              regValid
);
  // R5
  blank_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3) |-> (comboOut == '0));

  for (genvar g = 0; g < LANE_CNT; g++) begin : gZero
    // R2
    msb_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (mode == 2'd0 && idxVec[g*LANE_W + LANE_W - 1]) |-> (comboOut[g*LANE_W +: LANE_W] == '0));
  end

  if (REG_STAGE) begin : gRegChk
    // R7
    capture_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> (regOut == $past(comboOut)));
    // R7
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> regValid);
    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !regValid);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> $stable(regOut));
  end
endmodule

bind byte_shuffle_unit shuf_chk #(.REG_STAGE(REG_STAGE)) uChk (.*);

// File: tb/tb_byte_shuffle_unit.sv
module tb_byte_shuffle_unit;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [1:0]   mode;
  logic [127:0] tableA, tableB, idxVec;
  logic [63:0]  ctrlWord;
  logic [127:0] comboOut, regOut;
  logic         regValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  byte_shuffle_unit dut (.*);

  localparam int NVEC = 9;
  localparam logic [127:0] ID_IDX  = 128'h0F0E0D0C0B0A09080706050403020100;
  localparam logic [127:0] REV_IDX = 128'h000102030405060708090A0B0C0D0E0F;
  localparam logic [127:0] MSB_IDX = 128'h8F03FF708011253A9C07E04B81067F00;
  localparam logic [127:0] DUA_IDX = 128'h1F00100F3FE5A1121E0171089B170420;
  localparam logic [63:0]  ID_CW   = 64'hFEDCBA9876543210;
  localparam logic [63:0]  REV_CW  = 64'h0123456789ABCDEF;
  localparam logic [63:0]  MIX_CW  = 64'h5555AAAA0F0F3C3C;

  localparam logic [1:0]   T_MODE [NVEC] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3};
  localparam logic [127:0] T_IDX  [NVEC] = '{ID_IDX, REV_IDX, MSB_IDX, MSB_IDX, ID_IDX, REV_IDX,
                                             DUA_IDX, REV_IDX, MSB_IDX};
  localparam logic [63:0]  T_CW   [NVEC] = '{MIX_CW, MIX_CW, ID_CW, ID_CW, REV_CW, MIX_CW,
                                             MIX_CW, ID_CW, REV_CW};

  function automatic logic [127:0] model(logic [1:0] md, logic [127:0] ix, logic [63:0] cw,
                                         logic [127:0] ta, logic [127:0] tb);
    logic [127:0] r = '0;
    for (int l = 0; l < 16; l++) begin
      logic [7:0] ib = ix[8*l +: 8];
      int k;
      case (md)
        2'd0: begin
          k = int'(ib[3:0]);
          r[8*l +: 8] = ib[7] ? 8'h00 : ta[8*k +: 8];
        end
        2'd1: begin
          k = int'(cw[4*l +: 4]);
          r[8*l +: 8] = ta[8*k +: 8];
        end
        2'd2: begin
          k = int'(ib[4:0]);
          r[8*l +: 8] = (k < 16) ? ta[8*k +: 8] : tb[8*(k-16) +: 8];
        end
        default: r[8*l +: 8] = 8'h00;
      endcase
    end
    return r;
  endfunction

  function automatic string reqOf(logic [1:0] md, logic [127:0] ix);
    case (md)
      2'd0: return (ix == MSB_IDX) ? "R2" : "R1";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] exp, kept;
    rstN = 1'b0; inValid = 1'b1; mode = 2'd0; idxVec = ID_IDX; ctrlWord = ID_CW;
    for (int j = 0; j < 16; j++) begin
      tableA[8*j +: 8] = 8'h40 + 8'(j);
      tableB[8*j +: 8] = 8'hC0 + 8'(j);
    end
    repeat (3) @(posedge clk);
    #1;
    // R9 reset clears register even with strobe high
    chk("R9", regOut, '0);
    chk("R9", {127'b0, regValid}, '0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      mode = T_MODE[i]; idxVec = T_IDX[i]; ctrlWord = T_CW[i]; inValid = 1'b1;
      exp = model(T_MODE[i], T_IDX[i], T_CW[i], tableA, tableB);
      #1;
      // R6 result present before any clock edge
      chk(reqOf(T_MODE[i], T_IDX[i]), comboOut, exp);
      @(posedge clk); #1;
      chk("R7", regOut, exp);
      chk("R7", {127'b0, regValid}, 128'd1);
    end

    // R8 hold while strobe low
    @(negedge clk);
    kept = regOut;
    inValid = 1'b0; mode = 2'd0; idxVec = REV_IDX;
    #1;
    chk("R6", comboOut, model(2'd0, REV_IDX, '0, tableA, tableB));
    @(posedge clk); #1;
    chk("R8", regOut, kept);
    chk("R7", {127'b0, regValid}, '0);

    // R3 index vector ignored in control-word mode
    @(negedge clk);
    mode = 2'd1; ctrlWord = MIX_CW; idxVec = ID_IDX;
    #1; exp = comboOut;
    idxVec = MSB_IDX;
    #1;
    chk("R3", comboOut, exp);
    chk("R3", comboOut, model(2'd1, '0, MIX_CW, tableA, tableB));

    // R4 upper index bits ignored, table boundary 15/16
    @(negedge clk);
    mode = 2'd2;
    idxVec = 128'h0F100F10_0F100F10_0F100F10_0F100F10;
    #1; exp = comboOut;
    chk("R4", exp[15:0], {8'h4F, 8'hC0});
    idxVec = 128'hEFF0AFB0_6F700FF0_2F30CFD0_8F904F50;
    #1;
    chk("R4", comboOut, exp);

    // R1 bits 6:4 of index ignored
    @(negedge clk);
    mode = 2'd0; idxVec = 128'h7F7E7D7C_3B3A3938_57565554_13121110;
    #1;
    chk("R1", comboOut, ID_IDX + 128'h40404040_40404040_40404040_40404040);

    // R9 reset in mid run
    @(negedge clk); rstN = 1'b0; inValid = 1'b1;
    @(posedge clk); #1;
    chk("R9", regOut, '0);
    chk("R9", {127'b0, regValid}, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule